// File: doc/BRIEF.md
# AXI-Lite Address-Decoding Splitter

This block sits on a register bus between one AXI-Lite master and several AXI-Lite slaves, such as register files or clock-crossing bridges. It takes every read and write request from the single upstream port and forwards it to one of `NUM_PORTS` downstream ports. The downstream port is chosen by its address window. Each window is a base address and a mask, both set by parameters. A port claims an address when the masked address equals its masked base.

If no window claims an address, the splitter answers the request itself with a decode-error response and completes every handshake. The master therefore never waits on a slave that does not exist. The read and write paths each have their own decoder and state machine. Each path keeps at most one transaction in flight. The chosen port is latched when the address is accepted, and it steers the write data and the response of that transaction.

Top module: `axil_addr_splitter`

## Requirements
- R1: Downstream port i claims address `a` when `(a & PORT_MASK[i]) == (PORT_BASE[i] & PORT_MASK[i])`. A claimed request is presented on that port only, with its address unchanged. Port i's base and mask occupy bits `[i*ADDR_W +: ADDR_W]` of their parameters.
- R2: When several ports claim the same address, the port with the lowest index receives the request.
- R3: On an unclaimed write, the splitter accepts and discards the write-data beat, without asserting any downstream write-data valid. It then returns a write response of DECERR (code 2'b11), and no downstream port sees any activity.
- R4: On an unclaimed read, the splitter returns one read beat with response DECERR (2'b11) and read data of all zeros.
- R5: Each path allows at most one transaction in flight. `s_awready` stays low from the accepted write address until the write response handshake. `s_arready` stays low from the accepted read address until the read data handshake.
- R6: Write data and strobes go to the latched port. That port's write response code passes through unchanged (for example SLVERR, 2'b10, or OKAY, 2'b00).
- R7: Read data and the read response code come from the latched port without change.
- R8: Reads and writes are decoded and carried independently. A read completes normally while a write response is still pending.
- R9: After reset, all upstream response valids and all downstream request valids are low. `s_awready` and `s_arready` are high.
- R10: At any cycle, at most one downstream port has its address valid, write-data valid or read-address valid asserted, per channel.
- R11: An upstream response (`s_bvalid` or `s_rvalid`) that is not accepted stays asserted with a stable response code until the master accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awvalid | input | 1 | Upstream write address valid |
| s_awready | output | 1 | Upstream write address ready |
| s_awaddr | input | ADDR_W | Upstream write address |
| s_wvalid | input | 1 | Upstream write data valid |
| s_wready | output | 1 | Upstream write data ready |
| s_wdata | input | DATA_W | Upstream write data |
| s_wstrb | input | DATA_W/8 | Upstream write byte strobes |
| s_bvalid | output | 1 | Upstream write response valid |
| s_bready | input | 1 | Upstream write response ready |
| s_bresp | output | 2 | Upstream write response code |
| s_arvalid | input | 1 | Upstream read address valid |
| s_arready | output | 1 | Upstream read address ready |
| s_araddr | input | ADDR_W | Upstream read address |
| s_rvalid | output | 1 | Upstream read data valid |
| s_rready | input | 1 | Upstream read data ready |
| s_rdata | output | DATA_W | Upstream read data |
| s_rresp | output | 2 | Upstream read response code |
| m_awvalid | output | NUM_PORTS | Per-port write address valid |
| m_awready | input | NUM_PORTS | Per-port write address ready |
| m_awaddr | output | NUM_PORTS*ADDR_W | Per-port write address |
| m_wvalid | output | NUM_PORTS | Per-port write data valid |
| m_wready | input | NUM_PORTS | Per-port write data ready |
| m_wdata | output | NUM_PORTS*DATA_W | Per-port write data |
| m_wstrb | output | NUM_PORTS*DATA_W/8 | Per-port write strobes |
| m_bvalid | input | NUM_PORTS | Per-port write response valid |
| m_bready | output | NUM_PORTS | Per-port write response ready |
| m_bresp | input | NUM_PORTS*2 | Per-port write response code |
| m_arvalid | output | NUM_PORTS | Per-port read address valid |
| m_arready | input | NUM_PORTS | Per-port read address ready |
| m_araddr | output | NUM_PORTS*ADDR_W | Per-port read address |
| m_rvalid | input | NUM_PORTS | Per-port read data valid |
| m_rready | output | NUM_PORTS | Per-port read data ready |
| m_rdata | input | NUM_PORTS*DATA_W | Per-port read data |
| m_rresp | input | NUM_PORTS*2 | Per-port read response code |

## Verification
The assertions check four things on every cycle. A downstream request only ever appears on the lowest-index port that claims its address. Write data and read acceptance stay on the port latched at address time. No second address is taken while a path is busy, and a pending response stays stable. They also check that an unclaimed transaction never reaches a downstream port and is answered with DECERR and zero data. Other behaviours need the bench's scenarios. These are the exact routing of data and strobes across a full sweep of address windows, the pass-through of each slave's own response code, and the reset state. They also include a read that completes while a write response is held back by the master.

// File: rtl/axil_split_pkg.sv
// Shared definitions for the AXI-Lite address splitter.
// Assumes the standard two-bit AXI response encoding.
package axil_split_pkg;

    localparam logic [1:0] AXRESP_OKAY   = 2'b00;
    localparam logic [1:0] AXRESP_DECERR = 2'b11;

    typedef enum logic [2:0] {
        WR_IDLE,
        WR_ADDR,
        WR_DATA,
        WR_RESP,
        WR_SINK,
        WR_ERR
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_ADDR,
        RD_RESP,
        RD_ERR
    } rd_state_e;

endpackage

// File: rtl/axil_split_decode.sv
// Address window decoder: compares an address against every port's
// base under that port's mask and reports the lowest-index match.
// Assumes base/mask parameters packed port 0 in the low bits.
module axil_split_decode #(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 16,
    parameter int IDX_W     = 2,
    parameter logic [NUM_PORTS*ADDR_W-1:0] PORT_BASE = '0,
    parameter logic [NUM_PORTS*ADDR_W-1:0] PORT_MASK = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    logic [NUM_PORTS-1:0] match;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : gen_win
        // Window compare for one port.
        assign match[g] = ((addr ^ PORT_BASE[g*ADDR_W +: ADDR_W])
                           & PORT_MASK[g*ADDR_W +: ADDR_W]) == '0;
    end

    // Priority pick: scanning downward leaves the lowest match in idx.
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/axil_split_wr.sv
// Write path of the splitter: accepts one write address, forwards
// address, data and response to the latched port, or sinks the data
// beat and answers DECERR when no port claimed the address.
// Assumes hit/idx decode the current s_awaddr.
module axil_split_wr
    import axil_split_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int STRB_W    = 4,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hit,
    input  logic [IDX_W-1:0]            idx,
    input  logic                        s_awvalid,
    output logic                        s_awready,
    input  logic [ADDR_W-1:0]           s_awaddr,
    input  logic                        s_wvalid,
    output logic                        s_wready,
    input  logic [DATA_W-1:0]           s_wdata,
    input  logic [STRB_W-1:0]           s_wstrb,
    output logic                        s_bvalid,
    input  logic                        s_bready,
    output logic [1:0]                  s_bresp,
    output logic [NUM_PORTS-1:0]        m_awvalid,
    input  logic [NUM_PORTS-1:0]        m_awready,
    output logic [NUM_PORTS*ADDR_W-1:0] m_awaddr,
    output logic [NUM_PORTS-1:0]        m_wvalid,
    input  logic [NUM_PORTS-1:0]        m_wready,
    output logic [NUM_PORTS*DATA_W-1:0] m_wdata,
    output logic [NUM_PORTS*STRB_W-1:0] m_wstrb,
    input  logic [NUM_PORTS-1:0]        m_bvalid,
    output logic [NUM_PORTS-1:0]        m_bready,
    input  logic [NUM_PORTS*2-1:0]      m_bresp
);

    wr_state_e         state;
    logic [IDX_W-1:0]  sel_q;
    logic [ADDR_W-1:0] addr_q;
    logic              sel_awready;
    logic              sel_wready;
    logic              sel_bvalid;
    logic [1:0]        sel_bresp;

    // Pick the handshake inputs of the latched port.
    always_comb begin
        sel_awready = 1'b0;
        sel_wready  = 1'b0;
        sel_bvalid  = 1'b0;
        sel_bresp   = AXRESP_OKAY;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (sel_q == IDX_W'(i)) begin
                sel_awready = m_awready[i];
                sel_wready  = m_wready[i];
                sel_bvalid  = m_bvalid[i];
                sel_bresp   = m_bresp[i*2 +: 2];
            end
        end
    end

    // Transaction sequencer for the write path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= WR_IDLE;
            sel_q  <= '0;
            addr_q <= '0;
        end else begin
            case (state)
                WR_IDLE: if (s_awvalid) begin
                    addr_q <= s_awaddr;
                    sel_q  <= idx;
                    state  <= hit ? WR_ADDR : WR_SINK;
                end
                WR_ADDR: if (sel_awready) state <= WR_DATA;
                WR_DATA: if (s_wvalid && sel_wready) state <= WR_RESP;
                WR_RESP: if (sel_bvalid && s_bready) state <= WR_IDLE;
                WR_SINK: if (s_wvalid) state <= WR_ERR;
                WR_ERR:  if (s_bready) state <= WR_IDLE;
                default: state <= WR_IDLE;
            endcase
        end
    end

    // Broadcast payloads; only the selected valid is ever raised.
    assign m_awaddr = {NUM_PORTS{addr_q}};
    assign m_wdata  = {NUM_PORTS{s_wdata}};
    assign m_wstrb  = {NUM_PORTS{s_wstrb}};

    // Steer handshakes between the upstream port and the latched port.
    always_comb begin
        s_awready = (state == WR_IDLE);
        s_wready  = 1'b0;
        s_bvalid  = 1'b0;
        s_bresp   = AXRESP_OKAY;
        m_awvalid = '0;
        m_wvalid  = '0;
        m_bready  = '0;
        case (state)
            WR_DATA: s_wready = sel_wready;
            WR_RESP: begin
                s_bvalid = sel_bvalid;
                s_bresp  = sel_bresp;
            end
            WR_SINK: s_wready = 1'b1;
            WR_ERR: begin
                s_bvalid = 1'b1;
                s_bresp  = AXRESP_DECERR;
            end
            default: ;
        endcase
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (sel_q == IDX_W'(i)) begin
                m_awvalid[i] = (state == WR_ADDR);
                m_wvalid[i]  = (state == WR_DATA) && s_wvalid;
                m_bready[i]  = (state == WR_RESP) && s_bready;
            end
        end
    end

endmodule

// File: rtl/axil_split_rd.sv
// Read path of the splitter: accepts one read address, forwards it to
// the latched port and returns that port's data, or returns a zero
// DECERR beat when no port claimed the address.
// Assumes hit/idx decode the current s_araddr.
module axil_split_rd
    import axil_split_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hit,
    input  logic [IDX_W-1:0]            idx,
    input  logic                        s_arvalid,
    output logic                        s_arready,
    input  logic [ADDR_W-1:0]           s_araddr,
    output logic                        s_rvalid,
    input  logic                        s_rready,
    output logic [DATA_W-1:0]           s_rdata,
    output logic [1:0]                  s_rresp,
    output logic [NUM_PORTS-1:0]        m_arvalid,
    input  logic [NUM_PORTS-1:0]        m_arready,
    output logic [NUM_PORTS*ADDR_W-1:0] m_araddr,
    input  logic [NUM_PORTS-1:0]        m_rvalid,
    output logic [NUM_PORTS-1:0]        m_rready,
    input  logic [NUM_PORTS*DATA_W-1:0] m_rdata,
    input  logic [NUM_PORTS*2-1:0]      m_rresp
);

    rd_state_e         state;
    logic [IDX_W-1:0]  sel_q;
    logic [ADDR_W-1:0] addr_q;
    logic              sel_arready;
    logic              sel_rvalid;
    logic [DATA_W-1:0] sel_rdata;
    logic [1:0]        sel_rresp;

    // Pick the handshake inputs and payload of the latched port.
    always_comb begin
        sel_arready = 1'b0;
        sel_rvalid  = 1'b0;
        sel_rdata   = '0;
        sel_rresp   = AXRESP_OKAY;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (sel_q == IDX_W'(i)) begin
                sel_arready = m_arready[i];
                sel_rvalid  = m_rvalid[i];
                sel_rdata   = m_rdata[i*DATA_W +: DATA_W];
                sel_rresp   = m_rresp[i*2 +: 2];
            end
        end
    end

    // Transaction sequencer for the read path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RD_IDLE;
            sel_q  <= '0;
            addr_q <= '0;
        end else begin
            case (state)
                RD_IDLE: if (s_arvalid) begin
                    addr_q <= s_araddr;
                    sel_q  <= idx;
                    state  <= hit ? RD_ADDR : RD_ERR;
                end
                RD_ADDR: if (sel_arready) state <= RD_RESP;
                RD_RESP: if (sel_rvalid && s_rready) state <= RD_IDLE;
                RD_ERR:  if (s_rready) state <= RD_IDLE;
                default: state <= RD_IDLE;
            endcase
        end
    end

    assign m_araddr = {NUM_PORTS{addr_q}};

    // Steer handshakes and return data for the read path.
    always_comb begin
        s_arready = (state == RD_IDLE);
        s_rvalid  = 1'b0;
        s_rdata   = '0;
        s_rresp   = AXRESP_OKAY;
        m_arvalid = '0;
        m_rready  = '0;
        case (state)
            RD_RESP: begin
                s_rvalid = sel_rvalid;
                s_rdata  = sel_rdata;
                s_rresp  = sel_rresp;
            end
            RD_ERR: begin
                s_rvalid = 1'b1;
                s_rresp  = AXRESP_DECERR;
            end
            default: ;
        endcase
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (sel_q == IDX_W'(i)) begin
                m_arvalid[i] = (state == RD_ADDR);
                m_rready[i]  = (state == RD_RESP) && s_rready;
            end
        end
    end

endmodule

// File: rtl/axil_addr_splitter.sv
// One-to-N AXI-Lite splitter. Each downstream port owns the window
// given by PORT_BASE/PORT_MASK (port i at bits [i*ADDR_W +: ADDR_W]);
// the lowest-index claiming port wins and unclaimed requests get a
// locally generated DECERR. Read and write paths are independent and
// each carries one transaction at a time.
module axil_addr_splitter #(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter logic [NUM_PORTS*ADDR_W-1:0] PORT_BASE = {16'h2000, 16'h2000, 16'h1000},
    parameter logic [NUM_PORTS*ADDR_W-1:0] PORT_MASK = {16'hF000, 16'hFF00, 16'hF000}
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               s_awvalid,
    output logic                               s_awready,
    input  logic [ADDR_W-1:0]                  s_awaddr,
    input  logic                               s_wvalid,
    output logic                               s_wready,
    input  logic [DATA_W-1:0]                  s_wdata,
    input  logic [DATA_W/8-1:0]                s_wstrb,
    output logic                               s_bvalid,
    input  logic                               s_bready,
    output logic [1:0]                         s_bresp,
    input  logic                               s_arvalid,
    output logic                               s_arready,
    input  logic [ADDR_W-1:0]                  s_araddr,
    output logic                               s_rvalid,
    input  logic                               s_rready,
    output logic [DATA_W-1:0]                  s_rdata,
    output logic [1:0]                         s_rresp,
    output logic [NUM_PORTS-1:0]               m_awvalid,
    input  logic [NUM_PORTS-1:0]               m_awready,
    output logic [NUM_PORTS*ADDR_W-1:0]        m_awaddr,
    output logic [NUM_PORTS-1:0]               m_wvalid,
    input  logic [NUM_PORTS-1:0]               m_wready,
    output logic [NUM_PORTS*DATA_W-1:0]        m_wdata,
    output logic [NUM_PORTS*(DATA_W/8)-1:0]    m_wstrb,
    input  logic [NUM_PORTS-1:0]               m_bvalid,
    output logic [NUM_PORTS-1:0]               m_bready,
    input  logic [NUM_PORTS*2-1:0]             m_bresp,
    output logic [NUM_PORTS-1:0]               m_arvalid,
    input  logic [NUM_PORTS-1:0]               m_arready,
    output logic [NUM_PORTS*ADDR_W-1:0]        m_araddr,
    input  logic [NUM_PORTS-1:0]               m_rvalid,
    output logic [NUM_PORTS-1:0]               m_rready,
    input  logic [NUM_PORTS*DATA_W-1:0]        m_rdata,
    input  logic [NUM_PORTS*2-1:0]             m_rresp
);

    localparam int STRB_W = DATA_W / 8;
    localparam int IDX_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic             aw_hit;
    logic [IDX_W-1:0] aw_idx;
    logic             ar_hit;
    logic [IDX_W-1:0] ar_idx;

    axil_split_decode #(
        .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .PORT_BASE(PORT_BASE), .PORT_MASK(PORT_MASK)
    ) aw_dec_i (
        .addr(s_awaddr), .hit(aw_hit), .idx(aw_idx)
    );

    axil_split_decode #(
        .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .PORT_BASE(PORT_BASE), .PORT_MASK(PORT_MASK)
    ) ar_dec_i (
        .addr(s_araddr), .hit(ar_hit), .idx(ar_idx)
    );

    axil_split_wr #(
        .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .STRB_W(STRB_W), .IDX_W(IDX_W)
    ) wr_i (
        .clk(clk), .rst_n(rst_n), .hit(aw_hit), .idx(aw_idx),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp)
    );

    axil_split_rd #(
        .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) rd_i (
        .clk(clk), .rst_n(rst_n), .hit(ar_hit), .idx(ar_idx),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp)
    );

endmodule

// File: rtl/axil_addr_splitter_chk.sv
// Protocol and routing checker for axil_addr_splitter, bound to every
// instance. Tracks open transactions from the upstream handshakes and
// recomputes the expected port from the parameters on its own.
module axil_addr_splitter_chk #(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter logic [NUM_PORTS*ADDR_W-1:0] PORT_BASE = '0,
    parameter logic [NUM_PORTS*ADDR_W-1:0] PORT_MASK = '0
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        s_awvalid,
    input logic                        s_awready,
    input logic [ADDR_W-1:0]           s_awaddr,
    input logic                        s_bvalid,
    input logic                        s_bready,
    input logic [1:0]                  s_bresp,
    input logic                        s_arvalid,
    input logic                        s_arready,
    input logic [ADDR_W-1:0]           s_araddr,
    input logic                        s_rvalid,
    input logic                        s_rready,
    input logic [DATA_W-1:0]           s_rdata,
    input logic [1:0]                  s_rresp,
    input logic [NUM_PORTS-1:0]        m_awvalid,
    input logic [NUM_PORTS*ADDR_W-1:0] m_awaddr,
    input logic [NUM_PORTS-1:0]        m_wvalid,
    input logic [NUM_PORTS-1:0]        m_arvalid,
    input logic [NUM_PORTS*ADDR_W-1:0] m_araddr,
    input logic [NUM_PORTS-1:0]        m_rready
);

    // Lowest claiming port, or NUM_PORTS when none claims the address.
    function automatic int owner(input logic [ADDR_W-1:0] a);
        for (int i = 0; i < NUM_PORTS; i++) begin
            if ((a & PORT_MASK[i*ADDR_W +: ADDR_W]) ==
                (PORT_BASE[i*ADDR_W +: ADDR_W] & PORT_MASK[i*ADDR_W +: ADDR_W]))
                return i;
        end
        return NUM_PORTS;
    endfunction

    logic wr_open, rd_open;
    int   wr_port, rd_port;

    // Follow each path's open transaction from upstream handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_open <= 1'b0;
            rd_open <= 1'b0;
            wr_port <= 0;
            rd_port <= 0;
        end else begin
            if (s_awvalid && s_awready) begin
                wr_open <= 1'b1;
                wr_port <= owner(s_awaddr);
            end else if (s_bvalid && s_bready) begin
                wr_open <= 1'b0;
            end
            if (s_arvalid && s_arready) begin
                rd_open <= 1'b1;
                rd_port <= owner(s_araddr);
            end else if (s_rvalid && s_rready) begin
                rd_open <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : gen_port_chk
        // R1 and R2: a forwarded address reaches its lowest claiming port.
        assert_aw_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
            m_awvalid[g] |-> owner(m_awaddr[g*ADDR_W +: ADDR_W]) == g);
        assert_ar_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
            m_arvalid[g] |-> owner(m_araddr[g*ADDR_W +: ADDR_W]) == g);
        assert_w_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
            m_wvalid[g] |-> (wr_open && wr_port == g));
        assert_r_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
            m_rready[g] |-> (rd_open && rd_port == g));
    end

    assert_miss_sink_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_open && wr_port == NUM_PORTS) |-> (m_awvalid == '0 && m_wvalid == '0));
    assert_miss_bresp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && wr_port == NUM_PORTS) |-> s_bresp == 2'b11);
    assert_miss_rbeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && rd_port == NUM_PORTS) |-> (s_rresp == 2'b11 && s_rdata == '0));
    assert_one_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_awvalid && s_awready) |-> !wr_open);
    assert_one_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_arvalid && s_arready) |-> !rd_open);
    assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_awvalid) && $onehot0(m_wvalid) && $onehot0(m_arvalid));
    assert_b_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));
    assert_r_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rresp)));

endmodule

bind axil_addr_splitter axil_addr_splitter_chk #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PORT_BASE(PORT_BASE), .PORT_MASK(PORT_MASK)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .m_awvalid(m_awvalid), .m_awaddr(m_awaddr), .m_wvalid(m_wvalid),
    .m_arvalid(m_arvalid), .m_araddr(m_araddr), .m_rready(m_rready)
);

// File: tb/axil_addr_splitter_tb_top.sv
// Bench: sweeps 256 addresses over three overlapping windows for both
// paths, with behavioural slaves on each downstream port.
module axil_addr_splitter_tb_top;

    localparam int NP = 3;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SW = DW / 8;
    localparam logic [NP*AW-1:0] P_BASE = {16'h2000, 16'h2000, 16'h1000};
    localparam logic [NP*AW-1:0] P_MASK = {16'hF000, 16'hFF00, 16'hF000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
    logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
    logic [DW-1:0] s_wdata = '0;
    logic [SW-1:0] s_wstrb = '0;
    logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0] s_bresp, s_rresp;
    logic [DW-1:0] s_rdata;
    logic [NP-1:0] m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
    logic [NP-1:0] m_arvalid, m_arready, m_rvalid, m_rready;
    logic [NP*AW-1:0] m_awaddr, m_araddr;
    logic [NP*DW-1:0] m_wdata, m_rdata;
    logic [NP*SW-1:0] m_wstrb;
    logic [NP*2-1:0] m_bresp, m_rresp;

    axil_addr_splitter #(
        .NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW),
        .PORT_BASE(P_BASE), .PORT_MASK(P_MASK)
    ) dut_i (.*);

    // Behavioural slaves: address readies alternate, data ready always.
    logic tog;
    always @(posedge clk) tog <= rst_n ? ~tog : 1'b0;
    assign m_awready = {NP{tog}};
    assign m_arready = {NP{~tog}};
    assign m_wready  = {NP{1'b1}};

    int            cnt_aw [NP];
    int            cnt_w  [NP];
    int            cnt_ar [NP];
    logic [AW-1:0] last_aw [NP];
    logic [DW-1:0] last_wd [NP];
    logic [SW-1:0] last_ws [NP];
    logic [AW-1:0] rd_a    [NP];

    for (genvar g = 0; g < NP; g++) begin : gen_slave
        logic bv, rv;
        assign m_bvalid[g] = bv;
        assign m_rvalid[g] = rv;
        assign m_bresp[g*2 +: 2] = (g == 1) ? 2'b10 : 2'b00;
        assign m_rresp[g*2 +: 2] = (g == 1) ? 2'b10 : 2'b00;
        assign m_rdata[g*DW +: DW] = {8'(8'hA0 + g), 8'h00, rd_a[g]};
        always @(posedge clk) begin
            if (!rst_n) begin
                bv <= 0; rv <= 0; cnt_aw[g] <= 0; cnt_w[g] <= 0; cnt_ar[g] <= 0;
                rd_a[g] <= '0; last_aw[g] <= '0; last_wd[g] <= '0; last_ws[g] <= '0;
            end else begin
                if (m_awvalid[g] && m_awready[g]) begin
                    cnt_aw[g] <= cnt_aw[g] + 1;
                    last_aw[g] <= m_awaddr[g*AW +: AW];
                end
                if (m_wvalid[g] && m_wready[g]) begin
                    cnt_w[g] <= cnt_w[g] + 1;
                    last_wd[g] <= m_wdata[g*DW +: DW];
                    last_ws[g] <= m_wstrb[g*SW +: SW];
                    bv <= 1'b1;
                end else if (bv && m_bready[g]) bv <= 1'b0;
                if (m_arvalid[g] && m_arready[g]) begin
                    cnt_ar[g] <= cnt_ar[g] + 1;
                    rd_a[g] <= m_araddr[g*AW +: AW];
                    rv <= 1'b1;
                end else if (rv && m_rready[g]) rv <= 1'b0;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_port(input logic [AW-1:0] a);
        for (int p = 0; p < NP; p++)
            if ((a & P_MASK[p*AW +: AW]) == (P_BASE[p*AW +: AW] & P_MASK[p*AW +: AW]))
                return p;
        return NP;
    endfunction

    function automatic int n_claims(input logic [AW-1:0] a);
        int n = 0;
        for (int p = 0; p < NP; p++)
            if ((a & P_MASK[p*AW +: AW]) == (P_BASE[p*AW +: AW] & P_MASK[p*AW +: AW]))
                n++;
        return n;
    endfunction

    // Present AW and W together; finish both handshakes.
    task automatic wr_issue(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [SW-1:0] st);
        bit a_done = 0, w_done = 0, af, wf;
        @(negedge clk);
        s_awvalid = 1; s_awaddr = a; s_wvalid = 1; s_wdata = d; s_wstrb = st;
        #1;
        while (!(a_done && w_done)) begin
            af = s_awvalid && s_awready;
            wf = s_wvalid && s_wready;
            @(posedge clk); #1;
            if (af) begin s_awvalid = 0; a_done = 1; end
            if (wf) begin s_wvalid = 0; w_done = 1; end
            @(negedge clk); #1;
        end
    endtask

    // Accept the write response; flag any address acceptance while open.
    task automatic wr_finish(output logic [1:0] r, output bit leak);
        bit got = 0;
        leak = 0;
        @(negedge clk); s_bready = 1; #1;
        while (!got) begin
            if (s_awready) leak = 1;
            if (s_bvalid) begin
                r = s_bresp; got = 1;
                @(posedge clk); #1; s_bready = 0;
            end else begin
                @(negedge clk); #1;
            end
        end
    endtask

    task automatic rd_xact(input logic [AW-1:0] a, output logic [DW-1:0] d,
                           output logic [1:0] r, output bit leak);
        bit done = 0, got = 0, af;
        leak = 0;
        @(negedge clk); s_arvalid = 1; s_araddr = a; #1;
        while (!done) begin
            af = s_arready;
            @(posedge clk); #1;
            if (af) begin s_arvalid = 0; done = 1; end
            @(negedge clk); #1;
        end
        s_rready = 1;
        while (!got) begin
            if (s_arready) leak = 1;
            if (s_rvalid) begin
                d = s_rdata; r = s_rresp; got = 1;
                @(posedge clk); #1; s_rready = 0;
            end else begin
                @(negedge clk); #1;
            end
        end
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog R5 actual=hang expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] r;
        logic [DW-1:0] d;
        bit leak;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R9: reset state.
        check(!s_bvalid && !s_rvalid && s_awready && s_arready, "R9 ready/valid",
              {s_bvalid, s_rvalid, s_awready, s_arready}, 4'b0011);
        check(m_awvalid == 0 && m_wvalid == 0 && m_arvalid == 0, "R9 downstream valids",
              {m_awvalid, m_wvalid, m_arvalid}, 0);

        for (int hi = 0; hi < 16; hi++) begin
            for (int mid = 0; mid < 16; mid++) begin
                logic [AW-1:0] a;
                logic [DW-1:0] wd;
                logic [SW-1:0] ws;
                int e, bw[NP], bar[NP];
                string tw, tr;
                bit ok;
                a  = {4'(hi), 4'(mid), 8'h5A};
                wd = {a, ~a};
                ws = 4'(hi) | 4'b0001;
                e  = exp_port(a);
                tw = (e == NP) ? "R3" : (n_claims(a) > 1) ? "R2" : "R1";
                tr = (e == NP) ? "R4" : (n_claims(a) > 1) ? "R2" : "R7";
                for (int p = 0; p < NP; p++) begin bw[p] = cnt_w[p]; bar[p] = cnt_ar[p]; end

                wr_issue(a, wd, ws);
                wr_finish(r, leak);
                // R10/R3: only the owning port saw the write, or none at all.
                ok = 1;
                for (int p = 0; p < NP; p++)
                    if (cnt_w[p] != bw[p] + ((p == e) ? 1 : 0)) ok = 0;
                check(ok, {tw, " R10 write target"}, a, 64'(e));
                if (e < NP)
                    check(last_aw[e] == a && last_wd[e] == wd && last_ws[e] == ws,
                          {tw, " R6 write payload"}, {last_aw[e], last_wd[e]}, {a, wd});
                check(r == ((e == NP) ? 2'b11 : (e == 1) ? 2'b10 : 2'b00),
                      {tw, " R6 bresp"}, r, (e == NP) ? 2'b11 : (e == 1) ? 2'b10 : 2'b00);
                check(!leak, "R5 write address blocked", leak, 0);

                rd_xact(a, d, r, leak);
                ok = 1;
                for (int p = 0; p < NP; p++)
                    if (cnt_ar[p] != bar[p] + ((p == e) ? 1 : 0)) ok = 0;
                check(ok, {tr, " R10 read target"}, a, 64'(e));
                check(d == ((e == NP) ? 32'h0 : {8'(8'hA0 + e), 8'h00, a}),
                      {tr, " rdata"}, d, (e == NP) ? 32'h0 : {8'(8'hA0 + e), 8'h00, a});
                check(r == ((e == NP) ? 2'b11 : (e == 1) ? 2'b10 : 2'b00),
                      {tr, " rresp"}, r, (e == NP) ? 2'b11 : (e == 1) ? 2'b10 : 2'b00);
                check(!leak, "R5 read address blocked", leak, 0);
            end
        end

        // R8/R11: hold a write response back while a read completes.
        begin
            logic [1:0] b0;
            wr_issue(16'h1234, 32'hCAFE0001, 4'hF);
            for (int k = 0; k < 10 && !s_bvalid; k++) begin @(negedge clk); #1; end
            b0 = s_bresp;
            repeat (3) @(negedge clk);
            #1;
            check(s_bvalid && s_bresp == b0, "R11 held write response", {s_bvalid, s_bresp},
                  {1'b1, b0});
            check(!s_awready, "R5 no second write while held", s_awready, 0);
            rd_xact(16'h2345, d, r, leak);
            check(d == {8'hA2, 8'h00, 16'h2345} && r == 2'b00, "R8 read during open write",
                  {d, r}, {8'hA2, 8'h00, 16'h2345, 2'b00});
            wr_finish(r, leak);
            check(r == 2'b00 && last_wd[0] == 32'hCAFE0001, "R8 write completes after read",
                  {r, last_wd[0]}, {2'b00, 32'hCAFE0001});
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule